// File: doc/BRIEF.md
# Dual-Role Serial Peripheral Interface Controller

This block is a byte-wide SPI port that works either as the bus master, generating the serial clock, or as a slave clocked by an external master. Software configures it through five registers on a small synchronous register bus. These are a configuration register, a read-only status register, a data register (the transmit byte on write, the last received byte on read), a clock-divide register and an interrupt-flag register. Every transfer moves one 8-bit frame in each direction at the same time. Both clock idle levels, both clock phases, and most-significant-first or least-significant-first ordering are supported.

In master mode, a write to the data register starts a frame. The serial clock then toggles once every N system clocks until sixteen edges have been produced. In slave mode, the serial clock, select and data inputs pass through synchronizers, and the frame is counted from the edges seen. With phase 0 the select line frames the transfer. With phase 1 a frame is framed by clock edges alone, so frames can follow back to back while select stays low.

The register port has no back-pressure: an access is taken on every cycle in which `bus_en` is high. Read data is valid in that same cycle. Writes and read side effects take effect at that clock edge.

Top module: `spi_ctrl`

## Requirements
- R1: After reset, all five registers read 0. In addition, `sck_o` is 0 and `sck_oe`, `mosi_oe` and `miso_oe` are 0, because the block comes up as a slave.
- R2: In the configuration register at offset 0x00, bits 1:0 always read 0 and writes to them have no effect. Bits 6:2 read back as written: bit 2 is the length select, bit 3 the phase, bit 4 the polarity, bit 5 master mode (1) and bit 6 the bit order. Bit 7 reads 0.
- R3: In master mode, `sck_o` changes level once every N system clocks, counted from the data-register write. N is the divide value at offset 0x0C with bit 0 cleared, or 8 if that value is below 8. A frame consists of exactly 16 clock edges.
- R4: When no master frame is running, `sck_o` equals the polarity bit (0 idles low, 1 idles high).
- R5: With phase 0, the first data bit is driven before the first clock edge, input is captured on odd edges and output advances on even edges. With phase 1, output advances on odd edges and input is captured on even edges.
- R6: With bit-order 0, bit 7 of the byte is shifted first. With bit-order 1, bit 0 is shifted first. This applies in both directions.
- R7: Writing the data register (0x08) while idle sets the byte that is sent, and in master mode starts a frame. Reading 0x08 returns the most recently received byte.
- R8: Status (0x04) bit 7 is set when a frame completes. It stays set until a read of status is followed by an access (read or write) to the data register. Status bits 5:0 read 0.
- R9: Interrupt-flag bit 0 (0x1C) is set when a frame completes. It is cleared only by writing 1 to that bit.
- R10: A data-register write while a frame is in progress is discarded: the byte being sent does not change. The write sets status bit 6, which clears in the same way as bit 7.
- R11: In slave mode with phase 0, a frame is loaded when `ssel_n_i` falls. It completes only when `ssel_n_i` rises after 16 edges, not before.
- R12: In slave mode with phase 1, a frame begins on the first clock edge while `ssel_n_i` is low and completes on the 16th edge. A further frame may follow without `ssel_n_i` being released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, same cycle |
| sck_i | input | 1 | Serial clock from an external master |
| sck_o | output | 1 | Serial clock when master |
| sck_oe | output | 1 | Serial clock output enable |
| ssel_n_i | input | 1 | Active-low slave select |
| mosi_i | input | 1 | Serial data in, slave mode |
| mosi_o | output | 1 | Serial data out, master mode |
| mosi_oe | output | 1 | Master data output enable |
| miso_i | input | 1 | Serial data in, master mode |
| miso_o | output | 1 | Serial data out, slave mode |
| miso_oe | output | 1 | Slave data output enable while selected |

## Verification
A corrupted edge counter or divider shows up on `sck_o` within one half period as an edge in the wrong cycle or a wrong total edge count. A wrong shift direction or a phase-swapped capture shows on `mosi_o` at the first bit of a frame, and later as a wrong byte read back from the data register. Flag and collision errors only become visible when the registers are read, so the bench reads status and the interrupt flag right after every frame and in the middle of one. In slave mode, a framing error appears as a done bit that is set too early (before the select line rises) or never set while select is held low.

// File: rtl/spi_ctrl_pkg.sv
package spi_ctrl_pkg;
  localparam int unsigned AW = 5;

  localparam logic [AW-1:0] ADR_CFG  = 5'h00;
  localparam logic [AW-1:0] ADR_STAT = 5'h04;
  localparam logic [AW-1:0] ADR_DATA = 5'h08;
  localparam logic [AW-1:0] ADR_DIV  = 5'h0C;
  localparam logic [AW-1:0] ADR_FLAG = 5'h1C;

  // configuration bits 6:2, most significant first
  typedef struct packed {
    logic lsb_first;
    logic master;
    logic pol;
    logic pha;
    logic len;
  } cfg_t;
endpackage

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
  parameter int DIV_W   = 8,
  parameter int MIN_DIV = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic [DIV_W-1:0] div_cfg,
  output logic             edge_o,
  output logic             lvl_o
);
  localparam logic [DIV_W-1:0] FLOOR = DIV_W'(MIN_DIV);

  logic [DIV_W-1:0] div_eff, div_q, cnt_q;
  logic             lvl_q;

  always_comb begin
    if (div_cfg < FLOOR) div_eff = FLOOR;
    else                 div_eff = {div_cfg[DIV_W-1:1], 1'b0};
  end

  assign edge_o = run && !start && (cnt_q == div_q - 1'b1);
  assign lvl_o  = lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= FLOOR;
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (start) begin
      div_q <= div_eff;
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (run) begin
      if (edge_o) begin
        cnt_q <= '0;
        lvl_q <= ~lvl_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic ssel_n_i,
  input  logic mosi_i,
  output logic sck_edge,
  output logic sel_act,
  output logic sel_fall,
  output logic sel_rise,
  output logic mosi_s
);
  logic [STAGES-1:0][2:0] stg_q;
  logic [2:0] now;
  logic       sck_d_q, seln_d_q;

  assign now = stg_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= 3'b100;
      sck_d_q  <= 1'b0;
      seln_d_q <= 1'b1;
    end else begin
      stg_q[0] <= {ssel_n_i, sck_i, mosi_i};
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      sck_d_q  <= now[1];
      seln_d_q <= now[2];
    end
  end

  assign sck_edge = now[1] ^ sck_d_q;
  assign sel_act  = !now[2];
  assign sel_fall = !now[2] && seln_d_q;
  assign sel_rise = now[2] && !seln_d_q;
  assign mosi_s   = now[0];
endmodule

// File: rtl/spi_shift_eng.sv
module spi_shift_eng #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] tx,
  input  logic          clr,
  input  logic          edge_i,
  input  logic          din,
  input  logic          pha,
  input  logic          lsb_first,
  output logic          dout,
  output logic          last_o,
  output logic          mid_o,
  output logic [DW-1:0] final_o,
  output logic [DW-1:0] sr_o
);
  localparam int EDGES = 2 * DW;
  localparam int CW    = $clog2(EDGES + 1);

  logic [CW-1:0] ecnt_q, e_num;
  logic [DW-1:0] sr_q, shifted;
  logic          samp_q, is_last, samp_edge, shift_edge, do_shift, shin;

  assign e_num      = ecnt_q + 1'b1;
  assign is_last    = (e_num == CW'(EDGES));
  assign samp_edge  = pha ? !e_num[0] : e_num[0];
  assign shift_edge = !samp_edge && !(pha && e_num == CW'(1));
  assign do_shift   = shift_edge || (pha && is_last);
  assign shin       = samp_edge ? din : samp_q;

  generate
    if (DW > 1) begin : g_wide
      assign shifted = lsb_first ? {shin, sr_q[DW-1:1]} : {sr_q[DW-2:0], shin};
    end else begin : g_single
      assign shifted = shin;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecnt_q <= '0;
      sr_q   <= '0;
      samp_q <= 1'b0;
    end else if (load) begin
      sr_q   <= tx;
      ecnt_q <= edge_i ? CW'(1) : '0;
    end else if (clr) begin
      ecnt_q <= '0;
    end else if (edge_i) begin
      if (samp_edge) samp_q <= din;
      if (do_shift)  sr_q   <= shifted;
      ecnt_q <= is_last ? '0 : e_num;
    end
  end

  assign dout    = lsb_first ? sr_q[0] : sr_q[DW-1];
  assign last_o  = edge_i && !load && !clr && is_last;
  assign mid_o   = (ecnt_q != '0);
  assign final_o = shifted;
  assign sr_o    = sr_q;
endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl
  import spi_ctrl_pkg::*;
#(
  parameter int DW          = 8,
  parameter int DIV_W       = 8,
  parameter int MIN_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          sck_i,
  output logic          sck_o,
  output logic          sck_oe,
  input  logic          ssel_n_i,
  input  logic          mosi_i,
  output logic          mosi_o,
  output logic          mosi_oe,
  input  logic          miso_i,
  output logic          miso_o,
  output logic          miso_oe
);
  localparam int STAT_LO = DW - 2;

  cfg_t             cfg_q;
  logic [DIV_W-1:0] div_q;
  logic [DW-1:0]    hold_q, rx_q;
  logic             done_q, wcol_q, seen_q, flag_q, m_busy_q, s_full_q;

  logic wr, rd, hit_cfg, hit_stat, hit_data, hit_div, hit_flag;
  logic xfer_busy, data_ok, collide, m_start, clear_stat, xfer_done;
  logic m_edge, m_lvl;
  logic s_edge, s_act, s_fall, s_rise, s_mosi;
  logic e_load, e_clr, e_edge, e_din, e_dout, e_last, e_mid;
  logic [DW-1:0] e_tx, e_final, e_sr;

  assign wr       = bus_en && bus_we;
  assign rd       = bus_en && !bus_we;
  assign hit_cfg  = (bus_addr == ADR_CFG);
  assign hit_stat = (bus_addr == ADR_STAT);
  assign hit_data = (bus_addr == ADR_DATA);
  assign hit_div  = (bus_addr == ADR_DIV);
  assign hit_flag = (bus_addr == ADR_FLAG);

  spi_sck_gen #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_sck (
    .clk(clk), .rst_n(rst_n), .start(m_start), .run(m_busy_q),
    .div_cfg(div_q), .edge_o(m_edge), .lvl_o(m_lvl)
  );

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .ssel_n_i(ssel_n_i), .mosi_i(mosi_i),
    .sck_edge(s_edge), .sel_act(s_act), .sel_fall(s_fall), .sel_rise(s_rise),
    .mosi_s(s_mosi)
  );

  assign xfer_busy = cfg_q.master ? m_busy_q : (s_act && (cfg_q.pha ? e_mid : 1'b1));
  assign data_ok   = wr && hit_data && !xfer_busy;
  assign collide   = wr && hit_data && xfer_busy;
  assign m_start   = data_ok && cfg_q.master;

  always_comb begin
    if (cfg_q.master) begin
      e_load = m_start;
      e_tx   = bus_wdata;
      e_clr  = 1'b0;
      e_edge = m_edge;
      e_din  = miso_i;
    end else begin
      e_load = cfg_q.pha ? (s_edge && s_act && !e_mid) : s_fall;
      e_tx   = hold_q;
      e_clr  = !s_act;
      e_edge = s_edge && s_act;
      e_din  = s_mosi;
    end
  end

  spi_shift_eng #(.DW(DW)) u_eng (
    .clk(clk), .rst_n(rst_n), .load(e_load), .tx(e_tx), .clr(e_clr),
    .edge_i(e_edge), .din(e_din), .pha(cfg_q.pha), .lsb_first(cfg_q.lsb_first),
    .dout(e_dout), .last_o(e_last), .mid_o(e_mid), .final_o(e_final), .sr_o(e_sr)
  );

  always_comb begin
    if (cfg_q.master)   xfer_done = m_busy_q && e_last;
    else if (cfg_q.pha) xfer_done = e_last;
    else                xfer_done = s_rise && s_full_q;
  end

  assign clear_stat = bus_en && hit_data && seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      div_q    <= '0;
      hold_q   <= '0;
      rx_q     <= '0;
      done_q   <= 1'b0;
      wcol_q   <= 1'b0;
      seen_q   <= 1'b0;
      flag_q   <= 1'b0;
      m_busy_q <= 1'b0;
      s_full_q <= 1'b0;
    end else begin
      if (wr && hit_cfg) cfg_q <= bus_wdata[6:2];
      if (wr && hit_div) div_q <= bus_wdata[DIV_W-1:0];
      if (data_ok)       hold_q <= bus_wdata;

      if (m_start)                    m_busy_q <= 1'b1;
      else if (e_last && cfg_q.master) m_busy_q <= 1'b0;

      if (s_fall)      s_full_q <= 1'b0;
      else if (e_last) s_full_q <= 1'b1;

      if (e_last && (cfg_q.master || cfg_q.pha))  rx_q <= e_final;
      else if (xfer_done)                         rx_q <= e_sr;

      if (rd && hit_stat)  seen_q <= 1'b1;
      else if (clear_stat) seen_q <= 1'b0;

      if (xfer_done)       done_q <= 1'b1;
      else if (clear_stat) done_q <= 1'b0;

      if (collide)         wcol_q <= 1'b1;
      else if (clear_stat) wcol_q <= 1'b0;

      if (xfer_done)                          flag_q <= 1'b1;
      else if (wr && hit_flag && bus_wdata[0]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_cfg)  bus_rdata = DW'({cfg_q, 2'b00});
    if (hit_stat) bus_rdata = {done_q, wcol_q, {STAT_LO{1'b0}}};
    if (hit_data) bus_rdata = rx_q;
    if (hit_div)  bus_rdata = DW'(div_q);
    if (hit_flag) bus_rdata = DW'(flag_q);
  end

  assign sck_o   = cfg_q.pol ^ m_lvl;
  assign sck_oe  = cfg_q.master;
  assign mosi_o  = e_dout;
  assign mosi_oe = cfg_q.master;
  assign miso_o  = e_dout;
  assign miso_oe = !cfg_q.master && s_act;
endmodule

// File: rtl/spi_ctrl_chk.sv
module spi_ctrl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_en,
  input logic          bus_we,
  input logic [4:0]    bus_addr,
  input logic [DW-1:0] bus_rdata,
  input logic          sck_o,
  input logic          pol,
  input logic          master,
  input logic          m_busy,
  input logic          busy,
  input logic          done,
  input logic          wcol,
  input logic          flag
);
  p_sck_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (master && !m_busy) |-> (sck_o == pol));

  p_sck_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (master && !m_busy && !$past(m_busy) && $stable(pol) && $stable(master)) |-> $stable(sck_o));

  p_cfg_rsvd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && bus_addr == 5'h00) |-> (bus_rdata[1:0] == 2'b00));

  p_stat_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && bus_addr == 5'h04) |-> (bus_rdata[DW-3:0] == '0));

  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(bus_en && bus_addr == 5'h08)) |=> done);

  p_flag_on_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> flag);

  p_wcol_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr == 5'h08 && busy) |=> wcol);
endmodule

bind spi_ctrl spi_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .sck_o(sck_o), .pol(cfg_q.pol), .master(cfg_q.master),
  .m_busy(m_busy_q), .busy(xfer_busy), .done(done_q), .wcol(wcol_q), .flag(flag_q)
);

// File: tb/spi_ctrl_bench.sv
module spi_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       bus_en = 0, bus_we = 0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic sck_i = 0, ssel_n_i = 1, mosi_i = 0, miso_i = 0;
  logic sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;

  spi_ctrl u_spi_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_i(sck_i), .sck_o(sck_o),
    .sck_oe(sck_oe), .ssel_n_i(ssel_n_i), .mosi_i(mosi_i), .mosi_o(mosi_o),
    .mosi_oe(mosi_oe), .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic bitsel(logic [7:0] v, int i, bit lsb);
    return lsb ? v[i] : v[7-i];
  endfunction

  // behavioural reference of a master frame
  bit m_mstr = 0, m_on = 0, m_pol = 0, m_pha = 0, m_lsb = 0;
  int m_n = 8, m_k = 0, m_t, m_i;
  logic [7:0] m_tx = '0, m_rx = '0;

  always @(posedge clk) begin
    if (!rst_n) m_on = 0;
    else if (m_on) begin
      if (m_k == 16 * m_n) m_on = 0;
      else m_k = m_k + 1;
    end else if (m_mstr && bus_en && bus_we && bus_addr == 5'h08) begin
      m_on = 1; m_k = 0; m_tx = bus_wdata;
    end
  end

  always @(negedge clk) begin
    if (m_on) begin
      m_t = m_k / m_n;
      if (m_t > 16) m_t = 16;
      check("R3/R4 sck level", sck_o, m_pol ^ m_t[0]);
      if (m_t < 16) begin
        m_i = m_pha ? ((m_t == 0) ? 0 : (m_t - 1) / 2) : m_t / 2;
        check("R5/R6/R10 mosi bit", mosi_o, bitsel(m_tx, m_i, m_lsb));
        miso_i = bitsel(m_rx, m_i, m_lsb);
      end
    end
  end

  task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 0;
  endtask

  task automatic run_master(input logic [7:0] dv, input bit pol, input bit pha, input bit lsb,
                            input logic [7:0] tx, input logic [7:0] rx);
    logic [7:0] r;
    bus_write(5'h0C, dv);
    bus_write(5'h00, {1'b0, lsb, 1'b1, pol, pha, 3'b000});
    m_mstr = 1; m_pol = pol; m_pha = pha; m_lsb = lsb; m_rx = rx;
    m_n = (dv < 8) ? 8 : (dv & 8'hFE);
    @(negedge clk);
    check("R4 idle level", sck_o, pol);
    bus_write(5'h08, tx);
    repeat (16 * m_n + 4) @(negedge clk);
    bus_read(5'h04, r); check("R8 done set", r, 8'h80);
    bus_read(5'h1C, r); check("R9 flag set", r, 8'h01);
    bus_read(5'h08, r); check("R7 received byte", r, rx);
    bus_read(5'h04, r); check("R8 done cleared", r, 8'h00);
    bus_write(5'h1C, 8'h01);
    bus_read(5'h1C, r); check("R9 flag cleared", r, 8'h00);
  endtask

  task automatic run_slave(input bit pha, input bit lsb, input logic [7:0] mo,
                           output logic [7:0] mi, input bit release_sel);
    mi = '0;
    if (!pha) mosi_i = bitsel(mo, 0, lsb);
    ssel_n_i = 0;
    for (int e = 1; e <= 16; e++) begin
      bit smp;
      int bi;
      repeat (12) @(negedge clk);
      smp = pha ? (e % 2 == 0) : (e % 2 == 1);
      if (smp) begin
        bi = pha ? (e / 2 - 1) : (e - 1) / 2;
        mi[lsb ? bi : 7 - bi] = miso_o;
      end
      sck_i = ~sck_i;
      if (!smp) begin
        if (pha) mosi_i = bitsel(mo, (e - 1) / 2, lsb);
        else if (e < 16) mosi_i = bitsel(mo, e / 2, lsb);
      end
    end
    repeat (12) @(negedge clk);
    if (release_sel) ssel_n_i = 1;
  endtask

  initial begin
    logic [7:0] r, got;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 sck_o", sck_o, 0);
    check("R1 output enables", {sck_oe, mosi_oe, miso_oe}, 3'b000);
    bus_read(5'h00, r); check("R1 cfg", r, 0);
    bus_read(5'h04, r); check("R1 status", r, 0);
    bus_read(5'h08, r); check("R1 data", r, 0);
    bus_read(5'h0C, r); check("R1 divide", r, 0);
    bus_read(5'h1C, r); check("R1 flag", r, 0);
    // R2 configuration field layout
    bus_write(5'h00, 8'hFF); bus_read(5'h00, r); check("R2 readback", r, 8'h7C);
    bus_write(5'h00, 8'h03); bus_read(5'h00, r); check("R2 reserved ignored", r, 8'h00);
    // master frames, several modes and divides
    run_master(8'd8,  0, 0, 0, 8'hA5, 8'h3C);
    run_master(8'd3,  1, 1, 0, 8'h5A, 8'hC3);
    run_master(8'd13, 0, 1, 1, 8'h81, 8'h7E);
    run_master(8'd10, 1, 0, 1, 8'h96, 8'h69);
    // R10 collision: write mid-frame is discarded
    bus_write(5'h0C, 8'd8);
    bus_write(5'h00, 8'h20);
    m_pol = 0; m_pha = 0; m_lsb = 0; m_n = 8; m_rx = 8'h2D;
    bus_write(5'h08, 8'h5C);
    repeat (20) @(negedge clk);
    bus_write(5'h08, 8'h11);
    bus_read(5'h04, r); check("R10 collision bit", r, 8'h40);
    repeat (16 * 8) @(negedge clk);
    bus_read(5'h04, r); check("R10/R8 both bits", r, 8'hC0);
    bus_read(5'h08, r); check("R10 received intact", r, 8'h2D);
    bus_read(5'h04, r); check("R10 bits cleared", r, 8'h00);
    bus_write(5'h1C, 8'h01);
    // R11 slave, phase 0, framed by select
    m_mstr = 0;
    bus_write(5'h00, 8'h10);
    sck_i = 1; repeat (6) @(negedge clk);
    bus_write(5'h08, 8'hC5);
    run_slave(0, 0, 8'h96, got, 0);
    bus_read(5'h04, r); check("R11 not done while selected", r, 8'h00);
    ssel_n_i = 1; repeat (6) @(negedge clk);
    bus_read(5'h04, r); check("R11 done after release", r, 8'h80);
    bus_read(5'h08, r); check("R11 received byte", r, 8'h96);
    check("R11/R6 sent byte", got, 8'hC5);
    // R12 slave, phase 1, back-to-back frames under one select
    bus_write(5'h00, 8'h48);
    sck_i = 0; repeat (6) @(negedge clk);
    bus_write(5'h08, 8'h3B);
    run_slave(1, 1, 8'hA7, got, 0);
    bus_read(5'h04, r); check("R12 done while selected", r, 8'h80);
    bus_read(5'h08, r); check("R12 first byte", r, 8'hA7);
    check("R12 first sent", got, 8'h3B);
    bus_write(5'h08, 8'h4E);
    run_slave(1, 1, 8'h1D, got, 1);
    repeat (6) @(negedge clk);
    bus_read(5'h04, r); check("R12 second done", r, 8'h80);
    bus_read(5'h08, r); check("R12 second byte", r, 8'h1D);
    check("R12 second sent", got, 8'h4E);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule